// File: doc/BRIEF.md
# Pixel Stream Gearbox for a 64-bit DMA Path

This block sits between a 64-bit DMA data path and a streaming disparity engine. In the inbound direction each 64-bit beat carries two 32-bit pixel words. The block hands these words to the engine one at a time, starting with the low half of the beat. In the outbound direction the engine delivers one 8-bit disparity value per transfer. The block gathers eight of them into a 64-bit beat, with the earliest value in the lowest byte. It raises a frame-end marker on the beat that carries the final disparity of a frame, so that a DMA transfer closes on the frame boundary.

All four data interfaces use valid/ready handshakes, and a transfer happens on a rising clock edge where both valid and ready are high. A sender keeps its valid high and its data stable until that transfer happens. The block obeys the same rules on the interfaces it drives. The frame is set by a width parameter and a height parameter. Their product must be a multiple of eight, so the last outbound beat of a frame is always full. The inbound and outbound sides share only the clock and the reset.

Top module: `dma_pixel_gearbox`

## Requirements
- R1: Each accepted inbound beat produces two pixel words. The first is in_tdata[31:0] and the second is in_tdata[63:32].
- R2: in_tready is high only when the block holds no unsent pixel, or when the second pixel of the held beat is accepted in the same cycle.
- R3: While pix_valid is high and pix_ready is low, pix_valid stays high and pix_data stays unchanged in the next cycle.
- R4: An outbound beat carries the disparities in arrival order. The first is in out_tdata[7:0] and the eighth is in out_tdata[63:56].
- R5: While out_tvalid is high and out_tready is low, out_tvalid, out_tdata and out_tlast stay unchanged in the next cycle.
- R6: disp_ready is low while a complete beat waits and out_tready is low. It is high whenever no complete beat waits or out_tready is high.
- R7: out_tlast is high on outbound beat number FRAME_W*FRAME_H/8-1, counted from zero after reset. It is low on all other beats. The numbering then restarts at zero for the next frame.
- R8: An active-low reset, asynchronous on assertion, drops pix_valid and out_tvalid and clears both lane counters and the frame beat count. It does this at any point in a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_tdata | input | 64 | Inbound beat carrying two pixels |
| in_tvalid | input | 1 | Inbound beat valid |
| in_tready | output | 1 | Block can take an inbound beat |
| pix_data | output | 32 | Pixel word to the engine |
| pix_valid | output | 1 | Pixel word valid |
| pix_ready | input | 1 | Engine takes the pixel word |
| disp_data | input | 8 | Disparity value from the engine |
| disp_valid | input | 1 | Disparity value valid |
| disp_ready | output | 1 | Block takes the disparity value |
| out_tdata | output | 64 | Outbound beat of eight disparities |
| out_tvalid | output | 1 | Outbound beat valid |
| out_tready | input | 1 | DMA takes the outbound beat |
| out_tlast | output | 1 | Outbound beat closes the frame |

## Verification
The hardest case to reach is the frame-closing beat held under back-pressure. In that case the eighth disparity has completed the beat, the DMA side refuses it for several cycles, the engine keeps offering the next frame's first value, and the marker must stay on the held beat rather than move to the next one. The stimulus runs phases with very low out_tready probability over a small frame of four beats, so this stall lands on the last beat repeatedly. A reset applied in the middle of a frame then checks that the beat numbering restarts at zero. Separate phases starve pix_ready while in_tvalid stays high, which checks that a second inbound beat is refused while a pixel is still unsent.

// File: rtl/gearbox_pkg.sv
package gearbox_pkg;

  // number of narrow elements carried in one wide beat
  function automatic int lanes_of(input int bus_w, input int elem_w);
    return bus_w / elem_w;
  endfunction

  // counter width for a count range of n values, never below one bit
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/gb_unpack.sv
module gb_unpack
  import gearbox_pkg::*;
#(
  parameter int BUS_W  = 64,
  parameter int ELEM_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [ELEM_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int LANES = lanes_of(BUS_W, ELEM_W);
  localparam int LW    = cnt_w(LANES);

  logic [BUS_W-1:0]  beat_q;
  logic              held_q;
  logic [LW-1:0]     lane_q;
  logic [ELEM_W-1:0] lane_arr [LANES];
  logic              last_lane, out_fire, in_fire;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_arr[g] = beat_q[g*ELEM_W +: ELEM_W];
  end

  assign last_lane = (lane_q == LW'(LANES - 1));
  assign out_fire  = held_q & out_ready;
  // refill in the same cycle the final lane leaves
  assign in_ready  = ~held_q | (last_lane & out_ready);
  assign in_fire   = in_valid & in_ready;
  assign out_valid = held_q;
  assign out_data  = lane_arr[lane_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      held_q <= 1'b0;
      lane_q <= '0;
    end else if (in_fire) begin
      beat_q <= in_data;
      held_q <= 1'b1;
      lane_q <= '0;
    end else if (out_fire) begin
      if (last_lane) begin
        held_q <= 1'b0;
        lane_q <= '0;
      end else begin
        lane_q <= lane_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gb_pack.sv
module gb_pack
  import gearbox_pkg::*;
#(
  parameter int BUS_W  = 64,
  parameter int ELEM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ELEM_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [BUS_W-1:0]  out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              beat_done
);
  localparam int LANES = lanes_of(BUS_W, ELEM_W);
  localparam int LW    = cnt_w(LANES);

  logic [ELEM_W-1:0] slot_q [LANES];
  logic [LW-1:0]     fill_q;
  logic              full_q;
  logic              in_fire, out_fire;

  assign in_ready  = ~full_q | out_ready;
  assign in_fire   = in_valid & in_ready;
  assign out_fire  = full_q & out_ready;
  assign out_valid = full_q;
  assign beat_done = out_fire;

  for (genvar g = 0; g < LANES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (in_fire && fill_q == LW'(g))
        slot_q[g] <= in_data;
    end
    assign out_data[g*ELEM_W +: ELEM_W] = slot_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (out_fire)
        full_q <= 1'b0;
      if (in_fire) begin
        if (fill_q == LW'(LANES - 1)) begin
          fill_q <= '0;
          full_q <= 1'b1;
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gb_beat_counter.sv
module gb_beat_counter
  import gearbox_pkg::*;
#(
  parameter int LIMIT = 38400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic at_last
);
  localparam int CW = cnt_w(LIMIT);

  logic [CW-1:0] cnt_q;

  assign at_last = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (step)
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/dma_pixel_gearbox.sv
module dma_pixel_gearbox
  import gearbox_pkg::*;
#(
  parameter int BUS_W   = 64,
  parameter int PIX_W   = 32,
  parameter int DISP_W  = 8,
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  in_tdata,
  input  logic              in_tvalid,
  output logic              in_tready,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  input  logic [DISP_W-1:0] disp_data,
  input  logic              disp_valid,
  output logic              disp_ready,
  output logic [BUS_W-1:0]  out_tdata,
  output logic              out_tvalid,
  input  logic              out_tready,
  output logic              out_tlast
);
  localparam int OUT_LANES = lanes_of(BUS_W, DISP_W);
  localparam int FRAME_PIX = FRAME_W * FRAME_H;
  localparam int OUT_BEATS = FRAME_PIX / OUT_LANES;

  logic beat_done, last_beat;

  gb_unpack #(.BUS_W(BUS_W), .ELEM_W(PIX_W)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_tdata),
    .in_valid  (in_tvalid),
    .in_ready  (in_tready),
    .out_data  (pix_data),
    .out_valid (pix_valid),
    .out_ready (pix_ready)
  );

  gb_pack #(.BUS_W(BUS_W), .ELEM_W(DISP_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (disp_data),
    .in_valid  (disp_valid),
    .in_ready  (disp_ready),
    .out_data  (out_tdata),
    .out_valid (out_tvalid),
    .out_ready (out_tready),
    .beat_done (beat_done)
  );

  gb_beat_counter #(.LIMIT(OUT_BEATS)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (beat_done),
    .at_last (last_beat)
  );

  assign out_tlast = out_tvalid & last_beat;
endmodule

// File: rtl/dma_pixel_gearbox_chk.sv
module dma_pixel_gearbox_chk #(
  parameter int BUS_W   = 64,
  parameter int PIX_W   = 32,
  parameter int DISP_W  = 8,
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_W-1:0]  in_tdata,
  input logic              in_tvalid,
  input logic              in_tready,
  input logic [PIX_W-1:0]  pix_data,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [DISP_W-1:0] disp_data,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [BUS_W-1:0]  out_tdata,
  input logic              out_tvalid,
  input logic              out_tready,
  input logic              out_tlast
);
  localparam int BEATS = (FRAME_W * FRAME_H) / (BUS_W / DISP_W);

  int unsigned seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen_q <= 0;
    else if (out_tvalid && out_tready)
      seen_q <= (seen_q == BEATS - 1) ? 0 : seen_q + 1;
  end

  // R2
  no_refill_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |-> !in_tready);

  // R3
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

  // R5
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && !out_tready) |=> (out_tvalid && $stable(out_tdata) && $stable(out_tlast)));

  // R6
  disp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && !out_tready) |-> !disp_ready);

  // R6
  disp_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_tvalid || out_tready) |-> disp_ready);

  // R7
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tvalid |-> (out_tlast == (seen_q == BEATS - 1)));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!pix_valid && !out_tvalid));
endmodule

bind dma_pixel_gearbox dma_pixel_gearbox_chk #(
  .BUS_W(BUS_W), .PIX_W(PIX_W), .DISP_W(DISP_W),
  .FRAME_W(FRAME_W), .FRAME_H(FRAME_H)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_tdata(in_tdata), .in_tvalid(in_tvalid), .in_tready(in_tready),
  .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .disp_data(disp_data), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .out_tdata(out_tdata), .out_tvalid(out_tvalid), .out_tready(out_tready),
  .out_tlast(out_tlast)
);

// File: tb/dma_pixel_gearbox_test.sv
module dma_pixel_gearbox_test;
  localparam int FW    = 8;
  localparam int FH    = 4;
  localparam int BEATS = FW * FH / 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] in_tdata = '0;
  logic        in_tvalid = 1'b0;
  logic        in_tready;
  logic [31:0] pix_data;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [7:0]  disp_data = '0;
  logic        disp_valid = 1'b0;
  logic        disp_ready;
  logic [63:0] out_tdata;
  logic        out_tvalid;
  logic        out_tready = 1'b0;
  logic        out_tlast;

  always #2 clk = ~clk;  // 250 MHz

  dma_pixel_gearbox #(.FRAME_W(FW), .FRAME_H(FH)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_tdata(in_tdata), .in_tvalid(in_tvalid), .in_tready(in_tready),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .disp_data(disp_data), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .out_tdata(out_tdata), .out_tvalid(out_tvalid), .out_tready(out_tready),
    .out_tlast(out_tlast)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  logic [63:0] m_beat;
  bit          m_pend;
  int          m_lane;
  logic [7:0]  m_bytes[$];
  logic [63:0] m_word;
  bit          m_full;
  int          m_beatno;
  int          frames_seen = 0;

  logic [31:0] next_pix = 32'h1000_0000;
  logic [7:0]  next_disp = 8'h00;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_beat = '0; m_pend = 0; m_lane = 0;
    m_bytes.delete(); m_word = '0; m_full = 0; m_beatno = 0;
  endtask

  task automatic check_reset_state();
    check(pix_valid == 1'b0, "R8 pix_valid after reset", 64'(pix_valid), 0);
    check(out_tvalid == 1'b0, "R8 out_tvalid after reset", 64'(out_tvalid), 0);
    check(in_tready == 1'b1, "R8 in_tready after reset", 64'(in_tready), 1);
    check(disp_ready == 1'b1, "R8 disp_ready after reset", 64'(disp_ready), 1);
  endtask

  task automatic step(input int pv, input int pr, input int dv, input int orr);
    bit in_fire, pix_fire, disp_fire, out_fire;
    logic [63:0] exp_word;
    @(negedge clk);
    if (!(in_tvalid && !in_tready)) begin
      in_tvalid = ($urandom_range(99) < pv);
      in_tdata  = {next_pix + 32'd1, next_pix};
    end
    if (!(disp_valid && !disp_ready)) begin
      disp_valid = ($urandom_range(99) < dv);
      disp_data  = next_disp;
    end
    pix_ready  = ($urandom_range(99) < pr);
    out_tready = ($urandom_range(99) < orr);
    #1;
    // inbound side
    check(in_tready == (!m_pend || (m_lane == 1 && pix_ready)), "R2 in_tready",
          64'(in_tready), 64'(!m_pend || (m_lane == 1 && pix_ready)));
    check(pix_valid == m_pend, "R3 pix_valid", 64'(pix_valid), 64'(m_pend));
    if (m_pend)
      check(pix_data == (m_lane == 0 ? m_beat[31:0] : m_beat[63:32]), "R1 pix_data",
            64'(pix_data), 64'(m_lane == 0 ? m_beat[31:0] : m_beat[63:32]));
    // outbound side
    check(disp_ready == (!m_full || out_tready), "R6 disp_ready",
          64'(disp_ready), 64'(!m_full || out_tready));
    check(out_tvalid == m_full, "R5 out_tvalid", 64'(out_tvalid), 64'(m_full));
    if (m_full) begin
      exp_word = m_word;
      check(out_tdata == exp_word, "R4 out_tdata", out_tdata, exp_word);
      check(out_tlast == (m_beatno == BEATS - 1), "R7 out_tlast",
            64'(out_tlast), 64'(m_beatno == BEATS - 1));
    end
    in_fire   = in_tvalid && in_tready;
    pix_fire  = pix_valid && pix_ready;
    disp_fire = disp_valid && disp_ready;
    out_fire  = out_tvalid && out_tready;
    @(posedge clk);
    if (pix_fire) begin
      if (m_lane == 1) begin m_pend = 0; m_lane = 0; end
      else m_lane = 1;
    end
    if (in_fire) begin
      m_beat = in_tdata; m_pend = 1; m_lane = 0;
      next_pix = next_pix + 32'd2;
    end
    if (out_fire) begin
      if (m_beatno == BEATS - 1) begin frames_seen++; m_beatno = 0; end
      else m_beatno++;
      m_full = 0;
    end
    if (disp_fire) begin
      m_bytes.push_back(disp_data);
      next_disp = next_disp + 8'd1;
      if (m_bytes.size() == 8) begin
        for (int k = 0; k < 8; k++) m_word[k*8 +: 8] = m_bytes[k];
        m_bytes.delete();
        m_full = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    // free flow
    for (int i = 0; i < 600; i++) step(90, 90, 90, 90);
    // pixel consumer starved, inbound beats keep coming
    for (int i = 0; i < 600; i++) step(95, 15, 60, 80);
    // DMA output stalled hard, frame-end beat held
    for (int i = 0; i < 1200; i++) step(60, 70, 95, 8);
    // mid-frame reset: numbering restarts at zero
    for (int i = 0; i < 13; i++) step(80, 80, 100, 100);
    @(negedge clk);
    rst_n = 1'b0;
    in_tvalid = 1'b0; disp_valid = 1'b0;
    #1;
    model_reset();
    check_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 800; i++) step(70, 50, 80, 40);
    for (int i = 0; i < 600; i++) step(100, 100, 100, 100);
    check(frames_seen >= 4, "R7 frames closed", 64'(frames_seen), 4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule